// File: doc/BRIEF.md
# High-Side Switch Control and Protection

This block holds the digital control for three high-side load switches in a power-management companion device. Three command fields arrive from a serial control register: one bit for switch 0, one bit for switch 1 and a two-bit mode field for switch 2. A PWM pin can also drive switch 0. The block registers the three switch enables. It also keeps sticky status flags that the serial output word reports.

Several conditions force every switch off: a supply undervoltage, a thermal shutdown, and the period after any reset until a second correct watchdog trigger arrives. An overload turns off only the switch that reports it. Switch 2 has a low-power cyclic-wake mode. In this mode a sequencer pulses the switch on for a fixed number of timebase ticks once per programmable period. If a PWM rising edge arrives while the pulse is on, switch 2 stays off for as long as the mode remains selected.

Top module: `hs_switch_ctrl`

## Requirements
- R1: After reset, all enables and the whole status word are 0. The enables stay 0 through the first correct watchdog pulse and are released only after the second. A later reset locks them again.
- R2: Switch 0 is on when its command bit or the PWM input is 1. While the command bit is 1, the PWM level has no effect.
- R3: Switch 1 follows its command bit. Switch 2 mode field: 2'b00 off, 2'b01 on, 2'b10 or 2'b11 cyclic wake.
- R4: While undervoltage is present, all enables are forced to 0. Status bit 3 is set and stays set after the condition clears.
- R5: A thermal shutdown forces all enables to 0 and sets status bit 14. The enables stay at 0 until the input has cleared and a status read has then removed bit 14.
- R6: A thermal prewarning sets sticky status bit 4 and has no effect on the enables.
- R7: An overload on switch 0 sets sticky status bit 1. While the overload input for a switch is present, that switch is forced off.
- R8: A status read strobe clears each sticky flag whose condition is absent. A flag whose condition is still present stays set.
- R9: In cyclic mode, switch 2 is off for BASE_TICKS<<sel ticks and then on for ON_TICKS ticks, repeating.
- R10: A PWM rising edge during the cyclic on pulse turns switch 2 off until cyclic mode is left. An edge during the off phase has no effect.
- R11: Enables are registered and change one clock after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_sw0 | input | 1 | Serial command bit for switch 0 |
| cmd_sw1 | input | 1 | Serial command bit for switch 1 |
| sw2_mode | input | 2 | Switch 2 mode field |
| cyc_sel | input | 2 | Cyclic-wake period select |
| pwm_in | input | 1 | PWM pin |
| tick | input | 1 | Cyclic-wake timebase pulse |
| wd_ok | input | 1 | Correct watchdog trigger pulse |
| ovl_in | input | 3 | Per-switch overload |
| thermal_warn | input | 1 | Thermal prewarning |
| thermal_sd | input | 1 | Thermal shutdown |
| uv | input | 1 | Supply undervoltage |
| stat_rd | input | 1 | Status word read strobe |
| sw_en | output | 3 | Switch enables |
| status | output | 16 | Status word: bit1 overload, bit3 undervoltage, bit4 prewarning, bit14 shutdown |

## Verification
The bench builds the block with BASE_TICKS=4 and ON_TICKS=4 and holds the tick input high. Cyclic periods of 8, 20 and 36 clocks then finish in a few dozen cycles. This keeps whole-period duty counts and both fail-safe windows short enough to check directly. The release count keeps its default of 2, so both the first-pulse and the second-pulse behaviour are observed.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    localparam int STAT_W  = 16;
    localparam int ST_OVL0 = 1;
    localparam int ST_UV   = 3;
    localparam int ST_WARN = 4;
    localparam int ST_TSD  = 14;

    typedef enum logic [1:0] {
        CW_WAIT = 2'd0,
        CW_ON   = 2'd1,
        CW_OFF  = 2'd2
    } cw_state_e;

    typedef struct packed {
        logic tsd;
        logic warn;
        logic uv;
        logic ovl0;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    function automatic logic mode_is_cyclic(input logic [1:0] mode);
        return mode[1];
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input flags_t f);
        logic [STAT_W-1:0] w;
        w          = '0;
        w[ST_OVL0] = f.ovl0;
        w[ST_UV]   = f.uv;
        w[ST_WARN] = f.warn;
        w[ST_TSD]  = f.tsd;
        return w;
    endfunction

endpackage

// File: rtl/hsw_release.sv
module hsw_release #(
    parameter int TARGET = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wd_ok,
    output logic released
);
    localparam int CW = $clog2(TARGET + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wd_ok && (cnt != CW'(TARGET))) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign released = (cnt == CW'(TARGET));
endmodule

// File: rtl/hsw_flags.sv
module hsw_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic         rd,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= cond[i] | (q[i] & ~rd);
            end
        end
    end
endmodule

// File: rtl/hsw_cyclic.sv
module hsw_cyclic
    import hsw_pkg::*;
#(
    parameter int BASE_TICKS = 16,
    parameter int ON_TICKS   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tick,
    input  logic       pwm_rise,
    input  logic [1:0] sel,
    output logic       sw_on
);
    localparam int CNT_W = $clog2(BASE_TICKS * 8 + ON_TICKS + 1);

    cw_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;
    logic             wait_done;
    logic             on_done;

    assign term      = CNT_W'(BASE_TICKS) << sel;
    assign wait_done = (cnt == term - CNT_W'(1));
    assign on_done   = (cnt == CNT_W'(ON_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state <= CW_WAIT;
            cnt   <= '0;
        end else begin
            case (state)
                CW_WAIT: begin
                    if (tick) begin
                        if (wait_done) begin
                            state <= CW_ON;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CW_ONE();
                        end
                    end
                end
                CW_ON: begin
                    if (pwm_rise) begin
                        state <= CW_OFF;
                        cnt   <= '0;
                    end else if (tick) begin
                        if (on_done) begin
                            state <= CW_WAIT;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CW_ONE();
                        end
                    end
                end
                CW_OFF: begin
                    state <= CW_OFF;
                end
                default: begin
                    state <= CW_WAIT;
                    cnt   <= '0;
                end
            endcase
        end
    end

    function automatic logic [CNT_W-1:0] CW_ONE();
        return CNT_W'(1);
    endfunction

    assign sw_on = (state == CW_ON);
endmodule

// File: rtl/hs_switch_ctrl.sv
module hs_switch_ctrl
    import hsw_pkg::*;
#(
    parameter int BASE_TICKS = 16,
    parameter int ON_TICKS   = 4,
    parameter int WD_RELEASE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_sw0,
    input  logic              cmd_sw1,
    input  logic [1:0]        sw2_mode,
    input  logic [1:0]        cyc_sel,
    input  logic              pwm_in,
    input  logic              tick,
    input  logic              wd_ok,
    input  logic [2:0]        ovl_in,
    input  logic              thermal_warn,
    input  logic              thermal_sd,
    input  logic              uv,
    input  logic              stat_rd,
    output logic [2:0]        sw_en,
    output logic [STAT_W-1:0] status
);
    logic   released;
    logic   pwm_q;
    logic   pwm_rise;
    logic   cyc_on;
    logic   inhibit;
    logic   sw2_req;
    logic [2:0] en_next;
    flags_t flag_cond;
    flags_t flag_q;

    hsw_release #(.TARGET(WD_RELEASE)) u_release (
        .clk      (clk),
        .rst      (rst),
        .wd_ok    (wd_ok),
        .released (released)
    );

    always_comb begin
        flag_cond      = '0;
        flag_cond.tsd  = thermal_sd;
        flag_cond.warn = thermal_warn;
        flag_cond.uv   = uv;
        flag_cond.ovl0 = ovl_in[0];
    end

    hsw_flags #(.N(FLAG_W)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .cond (flag_cond),
        .rd   (stat_rd),
        .q    (flag_q)
    );

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= pwm_in;
    end
    assign pwm_rise = pwm_in & ~pwm_q;

    hsw_cyclic #(.BASE_TICKS(BASE_TICKS), .ON_TICKS(ON_TICKS)) u_cyclic (
        .clk      (clk),
        .rst      (rst),
        .enable   (released & mode_is_cyclic(sw2_mode)),
        .tick     (tick),
        .pwm_rise (pwm_rise),
        .sel      (cyc_sel),
        .sw_on    (cyc_on)
    );

    always_comb begin
        if (mode_is_cyclic(sw2_mode)) sw2_req = cyc_on;
        else                          sw2_req = sw2_mode[0];
    end

    assign inhibit    = ~released | uv | thermal_sd | flag_q.tsd;
    assign en_next[0] = (cmd_sw0 | pwm_in) & ~ovl_in[0];
    assign en_next[1] = cmd_sw1 & ~ovl_in[1];
    assign en_next[2] = sw2_req & ~ovl_in[2];

    always_ff @(posedge clk) begin
        if (rst || inhibit) sw_en <= '0;
        else                sw_en <= en_next;
    end

    assign status = pack_status(flag_q);
endmodule

// File: rtl/hsw_chk.sv
module hsw_chk (
    input logic        clk,
    input logic        rst,
    input logic        uv,
    input logic        thermal_sd,
    input logic [2:0]  ovl_in,
    input logic        wd_ok,
    input logic        stat_rd,
    input logic [2:0]  sw_en,
    input logic [15:0] status
);
    logic [1:0] wd_n;

    always_ff @(posedge clk) begin
        if (rst)                   wd_n <= 2'd0;
        else if (wd_ok && wd_n != 2'd2) wd_n <= wd_n + 2'd1;
    end

    // R1
    lock_until_wd_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_n < 2'd2) |-> (sw_en == 3'b000));

    // R4
    uv_off_chk: assert property (@(posedge clk) disable iff (rst)
        uv |=> (sw_en == 3'b000));

    // R5
    tsd_off_chk: assert property (@(posedge clk) disable iff (rst)
        thermal_sd |=> (sw_en == 3'b000));

    // R7
    ovl_off_chk: assert property (@(posedge clk) disable iff (rst)
        ovl_in[0] |=> !sw_en[0]);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (status[3] && !stat_rd) |=> status[3]);
endmodule

bind hs_switch_ctrl hsw_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .uv         (uv),
    .thermal_sd (thermal_sd),
    .ovl_in     (ovl_in),
    .wd_ok      (wd_ok),
    .stat_rd    (stat_rd),
    .sw_en      (sw_en),
    .status     (status)
);

// File: tb/hs_switch_ctrl_tb.sv
module hs_switch_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_sw0 = 0, cmd_sw1 = 0;
    logic [1:0]  sw2_mode = 0, cyc_sel = 0;
    logic        pwm_in = 0, tick = 1, wd_ok = 0;
    logic [2:0]  ovl_in = 0;
    logic        thermal_warn = 0, thermal_sd = 0, uv = 0, stat_rd = 0;
    logic [2:0]  sw_en;
    logic [15:0] status;

    int vectors = 0;
    int miss    = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    hs_switch_ctrl #(.BASE_TICKS(4), .ON_TICKS(4), .WD_RELEASE(2)) dut_i (
        .clk(clk), .rst(rst), .cmd_sw0(cmd_sw0), .cmd_sw1(cmd_sw1),
        .sw2_mode(sw2_mode), .cyc_sel(cyc_sel), .pwm_in(pwm_in), .tick(tick),
        .wd_ok(wd_ok), .ovl_in(ovl_in), .thermal_warn(thermal_warn),
        .thermal_sd(thermal_sd), .uv(uv), .stat_rd(stat_rd),
        .sw_en(sw_en), .status(status)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wd_pulse();
        wd_ok = 1; step(1); wd_ok = 0; step(1);
    endtask

    task automatic read_status();
        stat_rd = 1; step(1); stat_rd = 0; step(1);
    endtask

    task automatic count_sw2(input int n, output int ones);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (sw_en[2]) ones++;
        end
    endtask

    task automatic t_reset();
        chk(16'(sw_en), 16'h0, "R1 enables after reset");
        chk(status, 16'h0, "R1 status after reset");
        cmd_sw0 = 1; cmd_sw1 = 1;
        wd_pulse(); step(2);
        chk(16'(sw_en), 16'h0, "R1 locked after first watchdog");
        wd_pulse(); step(1);
        chk(16'(sw_en), 16'h3, "R1 released after second watchdog");
        rst = 1; step(1); rst = 0; step(2);
        chk(16'(sw_en), 16'h0, "R1 locked after new reset");
        wd_pulse(); wd_pulse(); step(1);
        chk(16'(sw_en), 16'h3, "R1 released again");
    endtask

    task automatic t_sw0();
        cmd_sw0 = 0; pwm_in = 1; step(2);
        chk(16'(sw_en[0]), 16'h1, "R2 pwm drives switch 0");
        pwm_in = 0; step(2);
        chk(16'(sw_en[0]), 16'h0, "R2 pwm low switch 0 off");
        cmd_sw0 = 1; step(2);
        chk(16'(sw_en[0]), 16'h1, "R2 command masks pwm low");
        pwm_in = 1; step(1);
        chk(16'(sw_en[0]), 16'h1, "R2 both sources on");
        pwm_in = 0; step(1);
    endtask

    task automatic t_sw12();
        cmd_sw1 = 0; step(1);
        chk(16'(sw_en[1]), 16'h0, "R11 switch 1 off after one clock");
        sw2_mode = 2'b01; step(2);
        chk(16'(sw_en[2]), 16'h1, "R3 mode 01 switch 2 on");
        sw2_mode = 2'b00; cmd_sw1 = 1; step(2);
        chk(16'(sw_en), 16'h3, "R3 mode 00 switch 2 off, switch 1 on");
        sw2_mode = 2'b01;
    endtask

    task automatic t_uv();
        step(2);
        uv = 1; step(2);
        chk(16'(sw_en), 16'h0, "R4 undervoltage forces off");
        chk(16'(status[3]), 16'h1, "R4 undervoltage flag set");
        read_status();
        chk(16'(status[3]), 16'h1, "R8 read while present keeps flag");
        uv = 0; step(2);
        chk(16'(status[3]), 16'h1, "R4 flag sticky after clear");
        chk(16'(sw_en), 16'h7, "R4 enables return");
        read_status();
        chk(16'(status[3]), 16'h0, "R8 read clears absent flag");
    endtask

    task automatic t_tsd();
        thermal_sd = 1; step(2);
        chk(16'(sw_en), 16'h0, "R5 shutdown forces off");
        chk(16'(status[14]), 16'h1, "R5 shutdown flag");
        thermal_sd = 0; step(3);
        chk(16'(sw_en), 16'h0, "R5 still off before read");
        read_status(); step(1);
        chk(16'(sw_en), 16'h7, "R5 released after read");
        chk(16'(status[14]), 16'h0, "R5 flag cleared");
    endtask

    task automatic t_warn();
        thermal_warn = 1; step(2);
        chk(status, 16'h0010, "R6 prewarning flag");
        chk(16'(sw_en), 16'h7, "R6 enables unaffected");
        thermal_warn = 0; step(2);
        chk(16'(status[4]), 16'h1, "R6 prewarning sticky");
        read_status();
        chk(16'(status[4]), 16'h0, "R8 prewarning cleared");
    endtask

    task automatic t_ovl();
        ovl_in = 3'b001; step(2);
        chk(16'(sw_en), 16'h6, "R7 overload turns switch 0 off");
        chk(16'(status[1]), 16'h1, "R7 overload flag");
        ovl_in = 3'b100; step(2);
        chk(16'(sw_en), 16'h3, "R7 overload turns switch 2 off");
        ovl_in = 3'b000; step(2);
        chk(16'(sw_en), 16'h7, "R7 switches return");
        chk(16'(status[1]), 16'h1, "R7 overload sticky");
        read_status();
        chk(16'(status[1]), 16'h0, "R8 overload cleared");
    endtask

    task automatic t_cyclic_period();
        int ones;
        cmd_sw0 = 0; cmd_sw1 = 0;
        sw2_mode = 2'b00; step(2);
        cyc_sel = 2'd0; sw2_mode = 2'b10; step(20);
        count_sw2(80, ones);
        chk(16'(ones), 16'd40, "R9 sel 0 duty over 10 periods");
        cyc_sel = 2'd2; sw2_mode = 2'b11; step(40);
        count_sw2(60, ones);
        chk(16'(ones), 16'd12, "R9 sel 2 duty over 3 periods");
    endtask

    task automatic t_failsafe();
        int ones;
        int guard;
        cyc_sel = 2'd3;
        sw2_mode = 2'b00; step(2); sw2_mode = 2'b10;
        guard = 0;
        while (!sw_en[2] && guard < 100) begin step(1); guard++; end
        pwm_in = 1; step(1); pwm_in = 0; step(3);
        chk(16'(sw_en[2]), 16'h0, "R10 edge in pulse turns off");
        count_sw2(40, ones);
        chk(16'(ones), 16'd0, "R10 stays off in cyclic mode");
        sw2_mode = 2'b00; step(2); sw2_mode = 2'b10;
        guard = 0;
        while (!sw_en[2] && guard < 100) begin step(1); guard++; end
        while (sw_en[2] && guard < 200) begin step(1); guard++; end
        step(5);
        pwm_in = 1; step(1); pwm_in = 0;
        count_sw2(72, ones);
        chk(16'(ones), 16'd8, "R10 edge in off phase ignored");
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        t_reset();
        t_sw0();
        t_sw12();
        t_uv();
        t_tsd();
        t_warn();
        t_ovl();
        t_cyclic_period();
        t_failsafe();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miss++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end
endmodule